// File: doc/BRIEF.md
# Redundant Geometry Descriptor Validator

This block watches the byte stream that a flash device returns when the host reads its self-description page. The page is sent as up to three identical 256-byte copies. For each copy the block checks a fixed four-byte signature and a 16-bit CRC. It stops at the first copy that passes both checks.

From that copy it publishes the geometry fields on registered outputs: the page data size, the spare size, pages per block, blocks per logical unit, the logical unit count, the address cycle counts and the ECC strength. A copy that fails either check never reaches the outputs, even if its fields were captured while it streamed in. The host pulses `start` before the read, feeds bytes with `byte_vld`, and waits for `done`.

Top module: `geom_page_validator`

## Requirements
- R1: After reset, `done`, `pass`, `copy_idx` and every geometry output are zero.
- R2: A copy fails unless its bytes at offsets 0, 1, 2 and 3 are 4Fh, 4Eh, 46h and 49h.
- R3: The checksum is a CRC-16 with polynomial 8005h and initial value 4F4Eh. It uses no reflection and no final XOR, and takes one byte per accepted beat, most significant bit first, over offsets 0 to 253. It must equal offset 254 (low byte) joined with offset 255 (high byte), or the copy fails.
- R4: If copy 0 passes, then in the cycle after its offset-255 byte is accepted, `done`=1, `pass`=1 and `copy_idx`=0.
- R5: A failing copy hands over to the next one. `copy_idx` reports the first passing copy (1 or 2), and `done` rises in the cycle after that copy's last byte.
- R6: If all three copies fail, then in the cycle after stream byte 767 `done`=1, `pass`=0 and `copy_idx`=3, and all geometry outputs read zero.
- R7: All geometry fields are little-endian:
  - `data_bytes` comes from offsets 80 to 83.
  - `spare_bytes` comes from offsets 84 to 85.
  - `pages_per_blk` comes from offsets 92 to 95.
  - `blks_per_lun` comes from offsets 96 to 99.
  - `lun_count` comes from offset 100.
  - `ecc_bits` comes from offset 112.
- R8: At offset 101, bits 3:0 give `row_cycles` and bits 7:4 give `col_cycles`.
- R9: Once `done` is set, bytes are ignored and the outputs hold until the next `start`. A `start` clears `done`, `pass`, `copy_idx` and the fields in the next cycle and begins a new check.
- R10: Cycles with `byte_vld` low neither advance the offset nor affect the CRC, whatever `byte_in` holds.
- R11: Geometry outputs stay zero unless `pass` is 1, and only a passing copy's fields are published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new check; clears results |
| byte_vld | input | 1 | `byte_in` carries a stream byte this cycle |
| byte_in | input | 8 | Stream byte |
| done | output | 1 | Check finished |
| pass | output | 1 | A copy passed |
| copy_idx | output | 2 | Index of the passing copy, 3 if none |
| data_bytes | output | 32 | Data bytes per page |
| spare_bytes | output | 16 | Spare bytes per page |
| pages_per_blk | output | 32 | Pages per block |
| blks_per_lun | output | 32 | Blocks per logical unit |
| lun_count | output | 8 | Number of logical units |
| row_cycles | output | 4 | Row address cycles |
| col_cycles | output | 4 | Column address cycles |
| ecc_bits | output | 8 | Correctable bits |

## Verification
An offset counter that slips by one beat moves the signature, CRC and field windows. This shows up within one copy as a wrong `copy_idx` or a spurious failure in the cycle after the 256th byte. A wrong CRC step or initial value makes every correct copy fail, so a clean stream ends with `copy_idx`=3 instead of 0. Shadow capture that leaks from a failed copy appears as a field value that the passing copy never carried. The fallback tests give the copies different field values so that this leak is visible.

// File: rtl/geom_page_validator.sv
module geom_page_validator #(
  parameter int          COPIES   = 3,
  parameter int          PAGE_LEN = 256,
  parameter logic [15:0] CRC_INIT = 16'h4F4E,
  parameter logic [15:0] CRC_POLY = 16'h8005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic        done,
  output logic        pass,
  output logic [1:0]  copy_idx,
  output logic [31:0] data_bytes,
  output logic [15:0] spare_bytes,
  output logic [31:0] pages_per_blk,
  output logic [31:0] blks_per_lun,
  output logic [7:0]  lun_count,
  output logic [3:0]  row_cycles,
  output logic [3:0]  col_cycles,
  output logic [7:0]  ecc_bits
);
  localparam int OFF_W = $clog2(PAGE_LEN);
  localparam logic [OFF_W-1:0] OFF_CRC_LO = OFF_W'(PAGE_LEN - 2);
  localparam logic [OFF_W-1:0] OFF_LAST   = OFF_W'(PAGE_LEN - 1);
  localparam logic [1:0]       LAST_COPY  = 2'(COPIES - 1);
  localparam logic [1:0]       NO_COPY    = 2'(COPIES);

  logic             busy, sig_ok;
  logic [OFF_W-1:0] off;
  logic [1:0]       cp;
  logic [15:0]      crc, crc_nx;
  logic [7:0]       crc_lo;
  logic [31:0]      sh_data, sh_pages, sh_blks;
  logic [15:0]      sh_spare;
  logic [7:0]       sh_lun, sh_cyc, sh_ecc;
  logic [7:0]       sig_exp;
  logic             copy_ok;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? CRC_POLY : 16'h0000);
    return r;
  endfunction

  always_comb begin
    case (off[1:0])
      2'd0:    sig_exp = 8'h4F;
      2'd1:    sig_exp = 8'h4E;
      2'd2:    sig_exp = 8'h46;
      default: sig_exp = 8'h49;
    endcase
  end

  assign crc_nx  = crc_step(crc, byte_in);
  assign copy_ok = sig_ok && ({byte_in, crc_lo} == crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sig_ok <= 1'b0; off <= '0; cp <= '0;
      crc <= CRC_INIT; crc_lo <= '0;
      sh_data <= '0; sh_spare <= '0; sh_pages <= '0; sh_blks <= '0;
      sh_lun <= '0; sh_cyc <= '0; sh_ecc <= '0;
      done <= 1'b0; pass <= 1'b0; copy_idx <= '0;
      data_bytes <= '0; spare_bytes <= '0; pages_per_blk <= '0; blks_per_lun <= '0;
      lun_count <= '0; row_cycles <= '0; col_cycles <= '0; ecc_bits <= '0;
    end else if (start) begin
      busy <= 1'b1; sig_ok <= 1'b1; off <= '0; cp <= '0; crc <= CRC_INIT;
      done <= 1'b0; pass <= 1'b0; copy_idx <= '0;
      data_bytes <= '0; spare_bytes <= '0; pages_per_blk <= '0; blks_per_lun <= '0;
      lun_count <= '0; row_cycles <= '0; col_cycles <= '0; ecc_bits <= '0;
    end else if (busy && byte_vld) begin
      off <= off + 1'b1;
      if (off < OFF_W'(4) && byte_in != sig_exp) sig_ok <= 1'b0;
      if (off < OFF_CRC_LO) crc <= crc_nx;
      if (off == OFF_CRC_LO) crc_lo <= byte_in;
      case (off)
        OFF_W'(80):  sh_data[7:0]    <= byte_in;
        OFF_W'(81):  sh_data[15:8]   <= byte_in;
        OFF_W'(82):  sh_data[23:16]  <= byte_in;
        OFF_W'(83):  sh_data[31:24]  <= byte_in;
        OFF_W'(84):  sh_spare[7:0]   <= byte_in;
        OFF_W'(85):  sh_spare[15:8]  <= byte_in;
        OFF_W'(92):  sh_pages[7:0]   <= byte_in;
        OFF_W'(93):  sh_pages[15:8]  <= byte_in;
        OFF_W'(94):  sh_pages[23:16] <= byte_in;
        OFF_W'(95):  sh_pages[31:24] <= byte_in;
        OFF_W'(96):  sh_blks[7:0]    <= byte_in;
        OFF_W'(97):  sh_blks[15:8]   <= byte_in;
        OFF_W'(98):  sh_blks[23:16]  <= byte_in;
        OFF_W'(99):  sh_blks[31:24]  <= byte_in;
        OFF_W'(100): sh_lun          <= byte_in;
        OFF_W'(101): sh_cyc          <= byte_in;
        OFF_W'(112): sh_ecc          <= byte_in;
        default: ;
      endcase
      if (off == OFF_LAST) begin
        if (copy_ok) begin
          busy <= 1'b0; done <= 1'b1; pass <= 1'b1; copy_idx <= cp;
          data_bytes <= sh_data; spare_bytes <= sh_spare;
          pages_per_blk <= sh_pages; blks_per_lun <= sh_blks;
          lun_count <= sh_lun; row_cycles <= sh_cyc[3:0]; col_cycles <= sh_cyc[7:4];
          ecc_bits <= sh_ecc;
        end else if (cp == LAST_COPY) begin
          busy <= 1'b0; done <= 1'b1; copy_idx <= NO_COPY;
        end else begin
          cp <= cp + 1'b1; crc <= CRC_INIT; sig_ok <= 1'b1;
        end
      end
    end
  end

  assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !pass);
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(copy_idx) && $stable(lun_count) && $stable(pass));
  assert_all_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !pass |-> copy_idx == NO_COPY && data_bytes == '0 && lun_count == '0);
  assert_pass_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done && copy_idx <= LAST_COPY);
  assert_clean_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pass |-> data_bytes == '0 && blks_per_lun == '0 && ecc_bits == '0 && row_cycles == '0);
endmodule

// File: tb/geom_page_validator_tb.sv
module geom_page_validator_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_vld = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        done, pass;
  logic [1:0]  copy_idx;
  logic [31:0] data_bytes, pages_per_blk, blks_per_lun;
  logic [15:0] spare_bytes;
  logic [7:0]  lun_count, ecc_bits;
  logic [3:0]  row_cycles, col_cycles;
  logic [7:0]  img [0:767];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  geom_page_validator u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_vld(byte_vld), .byte_in(byte_in),
    .done(done), .pass(pass), .copy_idx(copy_idx), .data_bytes(data_bytes),
    .spare_bytes(spare_bytes), .pages_per_blk(pages_per_blk), .blks_per_lun(blks_per_lun),
    .lun_count(lun_count), .row_cycles(row_cycles), .col_cycles(col_cycles), .ecc_bits(ecc_bits));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int base);
    logic [15:0] c = 16'h4F4E;
    for (int k = 0; k < 254; k++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ img[base+k][b];
        c = c << 1;
        if (fb) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) img[a+k] = v[8*k +: 8];
  endtask

  // alt=0 nominal geometry, alt=1 distinct values for leak detection
  task automatic make_copy(input int cpy, input bit alt, input bit bad_sig, input bit bad_crc);
    int base;
    logic [15:0] c;
    base = cpy * 256;
    for (int k = 0; k < 256; k++) img[base+k] = 8'((k * 7 + cpy * 13 + 5) & 255);
    img[base+0] = 8'h4F; img[base+1] = 8'h4E; img[base+2] = 8'h46; img[base+3] = 8'h49;
    if (bad_sig) img[base+2] = 8'h47;
    put32(base+80, alt ? 32'h1000 : 32'd2048);
    img[base+84] = alt ? 8'h80 : 8'h40; img[base+85] = 8'h00;
    put32(base+92, alt ? 32'd128 : 32'd64);
    put32(base+96, alt ? 32'd2048 : 32'd4096);
    img[base+100] = alt ? 8'd5 : 8'd2;
    img[base+101] = alt ? 8'h34 : 8'h23;
    img[base+112] = alt ? 8'd8 : 8'd1;
    c = ref_crc(base);
    if (bad_crc) c = c ^ 16'h0100;
    img[base+254] = c[7:0]; img[base+255] = c[15:8];
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input int first, input int last, input bit gaps);
    for (int k = first; k <= last; k++) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = img[k];
      if (gaps && (k % 5 == 0)) begin
        @(negedge clk); byte_vld = 1'b0; byte_in = 8'hA5;
        @(negedge clk); byte_in = 8'h3C;
      end
    end
    @(negedge clk); byte_vld = 1'b0; byte_in = 8'h00;
  endtask

  task automatic chk_nominal(input string req);
    chk({req, " data"}, data_bytes, 32'd2048);
    chk({req, " spare"}, 32'(spare_bytes), 32'd64);
    chk({req, " pages"}, pages_per_blk, 32'd64);
    chk({req, " blocks"}, blks_per_lun, 32'd4096);
    chk({req, " luns"}, 32'(lun_count), 32'd2);
    chk({req, " ecc"}, 32'(ecc_bits), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(done), 0); chk("R1 pass", 32'(pass), 0);
    chk("R1 idx", 32'(copy_idx), 0); chk("R1 data", data_bytes, 0);
    chk("R1 luns", 32'(lun_count), 0);
  endtask

  task automatic t_first_copy();
    make_copy(0, 0, 0, 0); make_copy(1, 1, 0, 0); make_copy(2, 1, 0, 0);
    pulse_start();
    send(0, 254, 0);
    chk("R4 not done before last byte", 32'(done), 0);
    @(negedge clk); byte_vld = 1'b1; byte_in = img[255];
    @(negedge clk); byte_vld = 1'b0;
    chk("R4 done", 32'(done), 1); chk("R4 pass", 32'(pass), 1);
    chk("R4 idx", 32'(copy_idx), 0);
    chk_nominal("R7");
    chk("R8 row", 32'(row_cycles), 3); chk("R8 col", 32'(col_cycles), 2);
  endtask

  task automatic t_sig_fallback();
    make_copy(0, 1, 1, 0); make_copy(1, 0, 0, 0); make_copy(2, 1, 0, 0);
    pulse_start();
    chk("R9 start clears done", 32'(done), 0);
    chk("R9 start clears fields", data_bytes, 0);
    send(0, 255, 0);
    chk("R2 bad signature not done", 32'(done), 0);
    send(256, 511, 0);
    chk("R5 idx after sig fail", 32'(copy_idx), 1);
    chk("R5 pass", 32'(pass), 1);
    chk_nominal("R11 no leak from failed copy");
  endtask

  task automatic t_crc_fallback();
    make_copy(0, 1, 0, 1); make_copy(1, 1, 0, 1); make_copy(2, 0, 0, 0);
    pulse_start();
    send(0, 511, 0);
    chk("R3 bad crc not done", 32'(done), 0);
    send(512, 767, 0);
    chk("R3 idx after crc fail", 32'(copy_idx), 2);
    chk("R5 done", 32'(done), 1);
    chk_nominal("R11");
  endtask

  task automatic t_all_fail();
    make_copy(0, 1, 1, 0); make_copy(1, 1, 0, 1); make_copy(2, 1, 1, 1);
    pulse_start();
    send(0, 767, 0);
    chk("R6 done", 32'(done), 1); chk("R6 pass", 32'(pass), 0);
    chk("R6 idx", 32'(copy_idx), 3); chk("R6 data", data_bytes, 0);
    chk("R6 blocks", blks_per_lun, 0); chk("R6 row", 32'(row_cycles), 0);
  endtask

  task automatic t_gaps();
    make_copy(0, 1, 0, 0); make_copy(1, 0, 0, 0); make_copy(2, 0, 0, 0);
    pulse_start();
    send(0, 255, 1);
    chk("R10 done with gaps", 32'(done), 1); chk("R10 idx", 32'(copy_idx), 0);
    chk("R10 data", data_bytes, 32'h1000); chk("R10 luns", 32'(lun_count), 5);
    chk("R8 alt row", 32'(row_cycles), 4); chk("R8 alt col", 32'(col_cycles), 3);
  endtask

  task automatic t_ignore_after_done();
    make_copy(0, 0, 0, 0); make_copy(1, 0, 0, 0); make_copy(2, 0, 0, 0);
    pulse_start();
    send(0, 255, 0);
    make_copy(0, 1, 0, 0);
    send(0, 255, 0);
    chk("R9 still done", 32'(done), 1); chk("R9 idx held", 32'(copy_idx), 0);
    chk_nominal("R9 fields held");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_first_copy();
        t_sig_fallback();
        t_crc_fallback();
        t_all_fail();
        t_gaps();
        t_ignore_after_done();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule